// File: doc/BRIEF.md
# Daisy-Chained Converter Readout Sequencer

This block runs a chain of serial analog-to-digital converters from the host side. A start request makes it pulse one conversion-start line that all converters share, so every device samples at the same moment. It then waits for the shared active-low end-of-conversion signal to finish a full cycle. The cycle is a high phase while converting, followed by the return low. Next it lowers chip select and leaves it low for a single unbroken serial frame of `N_DEV` × 16 clocks. That frame collects one 16-bit result from every converter.

The serial stream begins with the word of the device wired straight to the host. Each later 16-bit group comes from the next device further upstream. The block stores the words in an array indexed by position, with index 0 nearest the host, and raises a one-cycle valid strobe. If the end of conversion does not arrive within a programmable number of clocks, a one-cycle timeout strobe is raised instead. The devices take their next sample while the host is reading. A guard counter therefore stops a new start strobe until a minimum acquisition time has passed since the end of conversion.

The control sequence uses eight states:
- `ST_IDLE` leads to `ST_STROBE` on a start request, or to `ST_HOLD` if the guard has not yet expired.
- `ST_HOLD` leads to `ST_STROBE` once the guard reaches zero.
- `ST_STROBE` leads to `ST_ARM` after `CONV_W` cycles.
- `ST_ARM` leads to `ST_WAIT` when end-of-conversion goes high, or to `ST_FAULT` on timeout.
- `ST_WAIT` leads to `ST_SHIFT` when end-of-conversion goes low, or to `ST_FAULT` on timeout.
- `ST_SHIFT` leads to `ST_DONE` after the last serial clock falls.
- `ST_DONE` and `ST_FAULT` both return to `ST_IDLE`.

Top module: `adc_chain_reader`

## Requirements
- R1: While reset is held and after its release: cnvst_n_o=1, cs_n_o=1, sclk_o=0, valid_o=0, timeout_o=0.
- R2: A start_i pulse sampled in idle, with the guard expired, drives cnvst_n_o low for exactly CONV_W consecutive cycles, once.
- R3: cs_n_o falls only after eoc_n_i has been seen high and then low since the strobe. It falls on the cycle after eoc_n_i is sampled low.
- R4: cs_n_o stays low without a break for exactly N_DEV*16 rising edges of sclk_o. sclk_o is low whenever cs_n_o is high, and it idles low.
- R5: sdo_i is sampled on each rising edge of sclk_o, and the devices shift on the falling edge. The first bit of each 16-bit word is its MSB.
- R6: The first 16 received bits form word 0, which is data_o[15:0]. Word i is data_o[16*i+15:16*i], i.e. the nearest device comes first and each upstream device follows.
- R7: valid_o is high for exactly one cycle, the cycle in which cs_n_o returns high, and data_o holds the frame from then on.
- R8: If the wait for the end-of-conversion cycle lasts more than timeout_lim_i cycles, timeout_o pulses for one cycle. In that case no frame is read, valid_o stays low, and the next start works normally.
- R9: start_i pulses while a conversion or readout is in progress are ignored and cause no extra strobe.
- R10: A strobe never begins sooner than MIN_ACQ cycles after end-of-conversion was seen low. A start that arrives earlier waits, and the strobe follows as soon as the guard expires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Conversion request pulse |
| timeout_lim_i | input | TMO_W | Cycle limit for the end-of-conversion wait |
| eoc_n_i | input | 1 | Shared end-of-conversion, low when done |
| sdo_i | input | 1 | Serial data from the device nearest the host |
| cnvst_n_o | output | 1 | Shared conversion-start strobe, active low |
| cs_n_o | output | 1 | Chip select for the whole chain, active low |
| sclk_o | output | 1 | Serial clock |
| data_o | output | N_DEV*16 | Result array, word 0 in the low bits |
| valid_o | output | 1 | One-cycle result strobe |
| timeout_o | output | 1 | One-cycle end-of-conversion timeout strobe |

## Verification
Timing is counted from the outputs:
- The strobe goes low one cycle after the start pulse is sampled, or after the guard expires.
- cs_n_o falls one cycle after eoc_n_i is sampled low.
- Each serial bit takes 2*SCLK_HALF cycles.
- valid_o rises in the same cycle that cs_n_o rises.

The bench samples every output on the falling clock edge and measures these windows with cycle counters. It checks:
- the strobe width exactly;
- the rising-edge count per frame exactly;
- the gap from end of conversion to the next strobe against the window from MIN_ACQ to MIN_ACQ+4.

Each result word is compared against the scoreboard entry pushed when the conversion was requested.

// File: rtl/adc_chain_pkg.sv
package adc_chain_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HOLD,
        ST_STROBE,
        ST_ARM,
        ST_WAIT,
        ST_SHIFT,
        ST_DONE,
        ST_FAULT
    } rd_state_e;

endpackage

// File: rtl/adc_chain_timer.sv
module adc_chain_timer #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [TMO_W-1:0] lim_i,
    output logic             expired_o
);
    logic [TMO_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired_o = run_i && (cnt_q == lim_i);
endmodule

// File: rtl/adc_chain_sclk.sv
module adc_chain_sclk #(
    parameter int SCLK_HALF = 2,
    parameter int TOTAL     = 48
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic sclk_o,
    output logic sample_o,
    output logic last_o
);
    localparam int HW    = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;
    localparam int BIT_W = $clog2(TOTAL + 1);

    logic [HW-1:0]    half_q;
    logic [BIT_W-1:0] bit_q;
    logic             sclk_q;
    logic             tick;

    assign tick = (half_q == HW'(SCLK_HALF - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_q <= '0;
            bit_q  <= '0;
            sclk_q <= 1'b0;
        end else if (!en_i) begin
            half_q <= '0;
            bit_q  <= '0;
            sclk_q <= 1'b0;
        end else if (tick) begin
            half_q <= '0;
            sclk_q <= ~sclk_q;
            if (!sclk_q) begin
                bit_q <= bit_q + 1'b1;
            end
        end else begin
            half_q <= half_q + 1'b1;
        end
    end

    assign sclk_o   = sclk_q;
    assign sample_o = en_i && tick && !sclk_q;
    assign last_o   = en_i && tick && sclk_q && (bit_q == BIT_W'(TOTAL));
endmodule

// File: rtl/adc_chain_deser.sv
module adc_chain_deser #(
    parameter int N_DEV  = 3,
    parameter int WORD_W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      sample_i,
    input  logic                      sdo_i,
    output logic [N_DEV*WORD_W-1:0]   words_o
);
    localparam int TOTAL = N_DEV * WORD_W;

    logic [TOTAL-1:0] sr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (sample_i) begin
            sr_q <= {sr_q[TOTAL-2:0], sdo_i};
        end
    end

    for (genvar gi = 0; gi < N_DEV; gi++) begin : g_word
        assign words_o[gi*WORD_W +: WORD_W] = sr_q[TOTAL-1-gi*WORD_W -: WORD_W];
    end
endmodule

// File: rtl/adc_chain_reader.sv
module adc_chain_reader
    import adc_chain_pkg::*;
#(
    parameter int N_DEV     = 3,
    parameter int WORD_W    = 16,
    parameter int SCLK_HALF = 2,
    parameter int CONV_W    = 4,
    parameter int MIN_ACQ   = 12,
    parameter int TMO_W     = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_i,
    input  logic [TMO_W-1:0]          timeout_lim_i,
    input  logic                      eoc_n_i,
    input  logic                      sdo_i,
    output logic                      cnvst_n_o,
    output logic                      cs_n_o,
    output logic                      sclk_o,
    output logic [N_DEV*WORD_W-1:0]   data_o,
    output logic                      valid_o,
    output logic                      timeout_o
);
    localparam int TOTAL   = N_DEV * WORD_W;
    localparam int GUARD_W = $clog2(MIN_ACQ + 1);
    localparam int STR_W   = (CONV_W > 1) ? $clog2(CONV_W) : 1;

    rd_state_e          state_q, state_d;
    logic [GUARD_W-1:0] guard_q;
    logic [STR_W-1:0]   str_q;
    logic               guard_zero;
    logic               str_last;
    logic               tmo;
    logic               sample;
    logic               frame_last;
    logic               shifting;
    logic               waiting;

    assign guard_zero = (guard_q == '0);
    assign str_last   = (str_q == STR_W'(CONV_W - 1));
    assign shifting   = (state_q == ST_SHIFT);
    assign waiting    = (state_q == ST_ARM) || (state_q == ST_WAIT);

    adc_chain_timer #(.TMO_W(TMO_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (waiting),
        .lim_i     (timeout_lim_i),
        .expired_o (tmo)
    );

    adc_chain_sclk #(.SCLK_HALF(SCLK_HALF), .TOTAL(TOTAL)) u_sclk (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (shifting),
        .sclk_o   (sclk_o),
        .sample_o (sample),
        .last_o   (frame_last)
    );

    adc_chain_deser #(.N_DEV(N_DEV), .WORD_W(WORD_W)) u_deser (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample_i (sample),
        .sdo_i    (sdo_i),
        .words_o  (data_o)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = guard_zero ? ST_STROBE : ST_HOLD;
            ST_HOLD:   if (guard_zero) state_d = ST_STROBE;
            ST_STROBE: if (str_last) state_d = ST_ARM;
            ST_ARM: begin
                if (eoc_n_i)  state_d = ST_WAIT;
                else if (tmo) state_d = ST_FAULT;
            end
            ST_WAIT: begin
                if (!eoc_n_i) state_d = ST_SHIFT;
                else if (tmo) state_d = ST_FAULT;
            end
            ST_SHIFT:  if (frame_last) state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
            ST_FAULT:  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register with strobe-width and acquisition-guard counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            str_q   <= '0;
            guard_q <= '0;
        end else begin
            state_q <= state_d;
            str_q   <= (state_q == ST_STROBE) ? str_q + 1'b1 : '0;
            if (state_q == ST_WAIT && state_d == ST_SHIFT) begin
                guard_q <= GUARD_W'(MIN_ACQ);
            end else if (!guard_zero) begin
                guard_q <= guard_q - 1'b1;
            end
        end
    end

    // outputs decoded from state
    always_comb begin
        cnvst_n_o = 1'b1;
        cs_n_o    = 1'b1;
        valid_o   = 1'b0;
        timeout_o = 1'b0;
        unique case (state_q)
            ST_STROBE: cnvst_n_o = 1'b0;
            ST_SHIFT:  cs_n_o    = 1'b0;
            ST_DONE:   valid_o   = 1'b1;
            ST_FAULT:  timeout_o = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/adc_chain_reader_chk.sv
module adc_chain_reader_chk
    import adc_chain_pkg::*;
#(
    parameter int N_DEV   = 3,
    parameter int WORD_W  = 16,
    parameter int MIN_ACQ = 12
) (
    input logic                                clk,
    input logic                                rst_n,
    input logic                                eoc_n_i,
    input logic                                cnvst_n_o,
    input logic                                cs_n_o,
    input logic                                sclk_o,
    input logic                                valid_o,
    input logic                                timeout_o,
    input logic [$clog2(MIN_ACQ + 1)-1:0]      guard_q
);
    localparam int TOTAL = N_DEV * WORD_W;
    localparam int CW    = $clog2(TOTAL + 1) + 1;

    logic [CW-1:0] rise_q;
    logic          sclk_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rise_q <= '0;
            sclk_d <= 1'b0;
        end else begin
            sclk_d <= sclk_o;
            if (cs_n_o)                rise_q <= '0;
            else if (sclk_o && !sclk_d) rise_q <= rise_q + 1'b1;
        end
    end

    assert_strobe_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cnvst_n_o) |=> !cnvst_n_o);

    assert_read_after_eoc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n_o) |-> $past(!eoc_n_i));

    assert_frame_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n_o) |-> (rise_q == CW'(TOTAL)));

    assert_sclk_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> !sclk_o);

    assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    assert_timeout_no_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |-> (!valid_o && cs_n_o));

    assert_guard_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cnvst_n_o) |-> (guard_q == '0));
endmodule

bind adc_chain_reader adc_chain_reader_chk #(
    .N_DEV   (N_DEV),
    .WORD_W  (WORD_W),
    .MIN_ACQ (MIN_ACQ)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .eoc_n_i   (eoc_n_i),
    .cnvst_n_o (cnvst_n_o),
    .cs_n_o    (cs_n_o),
    .sclk_o    (sclk_o),
    .valid_o   (valid_o),
    .timeout_o (timeout_o),
    .guard_q   (guard_q)
);

// File: tb/sim_adc_chain_reader.sv
`timescale 1ns/1ps
module sim_adc_chain_reader;
    localparam int N_DEV    = 3;
    localparam int WORD_W   = 16;
    localparam int HALF     = 1;
    localparam int CONV_W   = 3;
    localparam int MIN_ACQ  = 150;
    localparam int TMO_W    = 16;
    localparam int TOTAL    = N_DEV * WORD_W;
    localparam int CONV_DLY = 30;
    localparam int LIM      = 100;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic             eoc_n = 1'b0;
    logic             sdo;
    logic             cnvst_n, cs_n, sclk, valid, tmo_o;
    logic [TOTAL-1:0] data;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit eoc_en = 1'b1;
    int eoc_cyc = 0;
    bit guard_chk = 1'b0;
    int n_strobe = 0;
    int n_frame = 0;
    int n_valid = 0;
    bit finished = 1'b0;

    logic [TOTAL-1:0] dev_load = '0;
    int               bitidx = 0;
    logic [TOTAL-1:0] exp_q[$];

    always #2 clk = ~clk;

    adc_chain_reader #(
        .N_DEV(N_DEV), .WORD_W(WORD_W), .SCLK_HALF(HALF),
        .CONV_W(CONV_W), .MIN_ACQ(MIN_ACQ), .TMO_W(TMO_W)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .timeout_lim_i(TMO_W'(LIM)), .eoc_n_i(eoc_n), .sdo_i(sdo),
        .cnvst_n_o(cnvst_n), .cs_n_o(cs_n), .sclk_o(sclk),
        .data_o(data), .valid_o(valid), .timeout_o(tmo_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // chain model: nearest device word leaves first, MSB first, shift on sclk fall
    assign sdo = (bitidx < TOTAL) ? dev_load[TOTAL-1-bitidx] : 1'b0;
    always @(negedge sclk or posedge cs_n) begin
        if (cs_n) bitidx = 0;
        else      bitidx = bitidx + 1;
    end

    // end-of-conversion model
    initial begin
        forever begin
            @(negedge cnvst_n);
            if (eoc_en) begin
                @(posedge clk); #1 eoc_n = 1'b1;
                repeat (CONV_DLY) @(posedge clk);
                #1 eoc_n = 1'b0;
                eoc_cyc = cyc;
            end
        end
    end

    // monitor: samples on falling clock edge
    int  low_run = 0;
    int  rises = 0;
    bit  prev_cn = 1'b1, prev_cs = 1'b1, prev_sclk = 1'b0, prev_valid = 1'b0;
    bit  saw_busy = 1'b0;
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (!cnvst_n) begin
                if (prev_cn) begin
                    n_strobe++;
                    saw_busy = 1'b0;
                    if (guard_chk) begin
                        chk((cyc - eoc_cyc) >= MIN_ACQ && (cyc - eoc_cyc) <= MIN_ACQ + 4,
                            "R10", "eoc-to-strobe gap", cyc - eoc_cyc, MIN_ACQ);
                        guard_chk = 1'b0;
                    end
                end
                low_run++;
            end else if (low_run > 0) begin
                chk(low_run == CONV_W, "R2", "strobe width", low_run, CONV_W);
                low_run = 0;
            end
            if (eoc_n) saw_busy = 1'b1;
            if (!cs_n && prev_cs) begin
                n_frame++;
                chk(saw_busy && !eoc_n, "R3", "read start after eoc cycle",
                    {saw_busy, eoc_n}, 2'b10);
            end
            if (!cs_n && sclk && !prev_sclk) rises++;
            if (cs_n && !prev_cs) begin
                chk(rises == TOTAL, "R4", "sclk rises in frame", rises, TOTAL);
                chk(!sclk, "R4", "sclk idle with cs high", sclk, 0);
                chk(valid, "R7", "valid with cs rise", valid, 1);
                rises = 0;
            end
            if (prev_valid) chk(!valid, "R7", "valid one cycle", valid, 0);
            if (valid) begin
                n_valid++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R6", "unexpected valid", data, 0);
                end else begin
                    logic [TOTAL-1:0] e;
                    e = exp_q.pop_front();
                    chk(data == e, "R6", "result words", data, e);
                end
            end
            prev_cn    = cnvst_n;
            prev_cs    = cs_n;
            prev_sclk  = sclk;
            prev_valid = valid;
        end
    end

    task automatic pulse_start();
        @(posedge clk); #1 start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
    endtask

    task automatic wait_valid(input string req);
        bit seen = 1'b0;
        for (int i = 0; i < 2000 && !seen; i++) begin
            @(negedge clk);
            if (valid) seen = 1'b1;
        end
        chk(seen, req, "valid arrived", seen, 1);
    endtask

    // driver: pushes the expected array, then requests a conversion
    task automatic run_conv(input logic [15:0] w0, input logic [15:0] w1,
                            input logic [15:0] w2, input string req);
        logic [TOTAL-1:0] e;
        dev_load = {w0, w1, w2};
        e = '0;
        e[15:0]  = w0;
        e[31:16] = w1;
        e[47:32] = w2;
        exp_q.push_back(e);
        pulse_start();
        wait_valid(req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int s0, f0, v0;
        bit seen;
        repeat (3) @(negedge clk);
        // R1 during reset
        chk(cnvst_n && cs_n && !sclk && !valid && !tmo_o, "R1", "outputs in reset",
            {cnvst_n, cs_n, sclk, valid, tmo_o}, 5'b11000);
        @(posedge clk); #1 rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(cnvst_n && cs_n && !sclk && !valid && !tmo_o, "R1", "outputs after reset",
            {cnvst_n, cs_n, sclk, valid, tmo_o}, 5'b11000);

        // R5/R6 distinct patterns
        run_conv(16'h1234, 16'hABCD, 16'h5A5A, "R6");
        repeat (200) @(posedge clk);
        run_conv(16'hFFFF, 16'h0000, 16'h8001, "R5");
        repeat (200) @(posedge clk);
        run_conv(16'h0001, 16'h8000, 16'h7FFE, "R5");
        repeat (200) @(posedge clk);

        // R9: start during readout is ignored
        s0 = n_strobe;
        dev_load = {16'hC3C3, 16'h3C3C, 16'h0F0F};
        exp_q.push_back({16'h0F0F, 16'h3C3C, 16'hC3C3});
        pulse_start();
        wait (!cs_n);
        pulse_start();
        pulse_start();
        wait_valid("R9");
        repeat (300) @(posedge clk);
        chk(n_strobe == s0 + 1, "R9", "strobes for busy starts", n_strobe - s0, 1);

        // R10: back-to-back start waits for acquisition guard
        run_conv(16'h2468, 16'h1357, 16'hFEDC, "R10");
        guard_chk = 1'b1;
        run_conv(16'hAAAA, 16'h5555, 16'h9999, "R10");
        chk(!guard_chk, "R10", "guarded strobe observed", guard_chk, 0);
        repeat (200) @(posedge clk);

        // R8: missing end of conversion
        eoc_en = 1'b0;
        f0 = n_frame;
        v0 = n_valid;
        pulse_start();
        seen = 1'b0;
        for (int i = 0; i < LIM + 60 && !seen; i++) begin
            @(negedge clk);
            if (tmo_o) seen = 1'b1;
        end
        chk(seen, "R8", "timeout pulse", seen, 1);
        repeat (20) @(negedge clk);
        chk(n_frame == f0 && n_valid == v0, "R8", "no read after timeout",
            n_frame - f0, 0);
        eoc_en = 1'b1;
        run_conv(16'h0BAD, 16'hF00D, 16'h1111, "R8");

        repeat (20) @(negedge clk);
        chk(exp_q.size() == 0, "R7", "scoreboard drained", exp_q.size(), 0);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule